// File: doc/BRIEF.md
# Verb-Addressed Scratch Mailbox

This block holds two 32-bit scratch words that a host audio controller reaches through vendor-defined verbs. Each verb arrives as a decoded strobe that carries a 12-bit verb ID and an 8-bit payload. Read verbs return a whole word. Write verbs load a single byte. The audio side uses the first word to tell a display-side agent the current stream format and whether that format is valid. The display side sees both words directly on output ports.

The block can tell the display agent about a change in one of two ways, and a mode input picks which. In toggle mode, an interrupt fires whenever a write changes the top bit of the first word. In kick mode, the top bit is ordinary storage, and the interrupt comes from a separate host-interrupt verb carrying a non-zero payload. Every interrupt is a one-cycle pulse. Each pulse also sets a sticky pending flag, which the display agent clears with an acknowledge input.

Top module: `scratch_mailbox`

## Requirements
- R1: Verb 0xFA6 reads word 0 and verb 0xFAB reads word 1, all 32 bits. `rsp_valid` is high for exactly the one cycle after any verb strobe. `rsp_data` is valid in that same cycle and holds the word as it stood when the strobe was sampled.
- R2: Verbs 0xFA7, 0xFA8, 0xFA9 and 0xFAA load the payload into word 0 bits 7:0, 15:8, 23:16 and 31:24 respectively. The new value shows on `scratch0_out` one cycle after the strobe. The display side reads word 0 as: bit 31 trigger, bit 30 format-valid, bits 15:0 format code.
- R3: Verbs 0xFAC, 0xFAD, 0xFAE and 0xFAF load word 1 bytes 0, 1, 2 and 3 respectively. Word 0 is left untouched.
- R4: A read strobe issued in the cycle right after a byte write to the same word returns the updated word.
- R5: When `legacy_mode` is 1, a 0xFAA write whose payload bit 7 differs from the current word-0 bit 31 raises `irq_pulse`. Rewriting the same bit raises nothing, and verb 0xF80 has no effect.
- R6: When `legacy_mode` is 0, a change of bit 31 raises nothing. Verb 0xF80 with a non-zero payload raises `irq_pulse`, and verb 0xF80 with a zero payload raises nothing.
- R7: `irq_pulse` lasts one cycle and appears the cycle after the triggering strobe. `irq_pending` rises with it and stays high until `irq_ack` is sampled high. A new event in the same cycle as an acknowledge keeps `irq_pending` set.
- R8: Reset clears both words, the response, the pulse and the pending flag.
- R9: A verb ID that is none of the above changes no state, and its response is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| verb_valid | input | 1 | Verb strobe, one cycle per verb |
| verb_id | input | 12 | Verb identifier |
| verb_data | input | 8 | Verb payload |
| legacy_mode | input | 1 | 1: interrupt on top-bit toggle; 0: interrupt by kick verb |
| irq_ack | input | 1 | Clears the pending flag |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Response word |
| irq_pulse | output | 1 | One-cycle interrupt toward the display agent |
| irq_pending | output | 1 | Sticky interrupt flag |
| scratch0_out | output | 32 | Word 0 as seen by the display side |
| scratch1_out | output | 32 | Word 1 as seen by the display side |

## Verification
The bench first builds the word from four distinct bytes and reads it back. This separates the byte lanes from each other and word 0 from word 1. It then writes the top byte several times in toggle mode: once with bit 7 unchanged, once flipped, once repeated and once flipped back. This separates "changed" from "set". In kick mode it repeats the same top-bit flips and sends the kick verb with zero and non-zero payloads, which shows that the interrupt source really moved. Unknown IDs, an acknowledge that coincides with an event, and a reset in mid-run cover the remaining corners.

// File: rtl/smbx_pkg.sv
package smbx_pkg;

  localparam int unsigned SMBX_NREG = 2;

  // Offset of the read verb of word r from the verb base.
  function automatic int unsigned read_slot(int unsigned r, int unsigned nbyte);
    return r * (nbyte + 1);
  endfunction

  // Offset of the byte-b write verb of word r from the verb base.
  function automatic int unsigned write_slot(int unsigned r, int unsigned b, int unsigned nbyte);
    return r * (nbyte + 1) + 1 + b;
  endfunction

  // True when a new top bit differs from the stored one.
  function automatic logic bit_flipped(logic old_b, logic new_b);
    return old_b ^ new_b;
  endfunction

endpackage

// File: rtl/smbx_decode.sv
module smbx_decode import smbx_pkg::*; #(
  parameter int unsigned VERB_W    = 12,
  parameter int unsigned NBYTE     = 4,
  parameter logic [11:0] VERB_BASE = 12'hFA6,
  parameter logic [11:0] INTR_VERB = 12'hF80
) (
  input  logic                       verb_valid,
  input  logic [VERB_W-1:0]          verb_id,
  output logic [SMBX_NREG-1:0]       rd_en,
  output logic [SMBX_NREG*NBYTE-1:0] wr_en,
  output logic                       kick_hit,
  output logic                       unknown
);
  localparam int unsigned SPAN = SMBX_NREG * (NBYTE + 1);

  logic [VERB_W-1:0] off;
  logic              in_window;

  assign off       = verb_id - VERB_W'(VERB_BASE);
  assign in_window = (off < VERB_W'(SPAN));
  assign kick_hit  = verb_valid && (verb_id == VERB_W'(INTR_VERB));
  assign unknown   = verb_valid && !in_window && !kick_hit;

  for (genvar r = 0; r < SMBX_NREG; r++) begin : g_word
    localparam int unsigned RD_OFF = read_slot(r, NBYTE);
    assign rd_en[r] = verb_valid && (off == VERB_W'(RD_OFF));
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      localparam int unsigned WR_OFF = write_slot(r, b, NBYTE);
      assign wr_en[r*NBYTE+b] = verb_valid && (off == VERB_W'(WR_OFF));
    end
  end
endmodule

// File: rtl/smbx_regfile.sv
module smbx_regfile import smbx_pkg::*; #(
  parameter int unsigned NBYTE  = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SMBX_NREG*NBYTE-1:0]        wr_en,
  input  logic [BYTE_W-1:0]                 wr_byte,
  output logic [SMBX_NREG*NBYTE*BYTE_W-1:0] words
);
  for (genvar i = 0; i < SMBX_NREG*NBYTE; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        words[i*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en[i]) words[i*BYTE_W +: BYTE_W] <= wr_byte;
    end
  end
endmodule

// File: rtl/smbx_irq.sv
module smbx_irq import smbx_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic legacy_mode,
  input  logic top_wr,
  input  logic top_new,
  input  logic top_old,
  input  logic kick_hit,
  input  logic kick_nonzero,
  input  logic irq_ack,
  output logic irq_event,
  output logic irq_pulse,
  output logic irq_pending
);
  logic toggle_evt;
  logic kick_evt;

  assign toggle_evt = top_wr && bit_flipped(top_old, top_new);
  assign kick_evt   = kick_hit && kick_nonzero;
  assign irq_event  = legacy_mode ? toggle_evt : kick_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse   <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      irq_pulse <= irq_event;
      if (irq_event)    irq_pending <= 1'b1;
      else if (irq_ack) irq_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/scratch_mailbox.sv
module scratch_mailbox import smbx_pkg::*; #(
  parameter int unsigned VERB_W    = 12,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NBYTE     = 4,
  parameter logic [11:0] VERB_BASE = 12'hFA6,
  parameter logic [11:0] INTR_VERB = 12'hF80,
  localparam int unsigned REG_W    = NBYTE * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              verb_valid,
  input  logic [VERB_W-1:0] verb_id,
  input  logic [BYTE_W-1:0] verb_data,
  input  logic              legacy_mode,
  input  logic              irq_ack,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_data,
  output logic              irq_pulse,
  output logic              irq_pending,
  output logic [REG_W-1:0]  scratch0_out,
  output logic [REG_W-1:0]  scratch1_out
);
  logic [SMBX_NREG-1:0]       rd_en;
  logic [SMBX_NREG*NBYTE-1:0] wr_en;
  logic                       kick_hit;
  logic                       verb_unknown;
  logic                       irq_event;
  logic [SMBX_NREG*REG_W-1:0] words;
  logic [REG_W-1:0]           rd_word;

  smbx_decode #(
    .VERB_W(VERB_W), .NBYTE(NBYTE), .VERB_BASE(VERB_BASE), .INTR_VERB(INTR_VERB)
  ) u_dec (
    .verb_valid(verb_valid), .verb_id(verb_id), .rd_en(rd_en),
    .wr_en(wr_en), .kick_hit(kick_hit), .unknown(verb_unknown)
  );

  smbx_regfile #(.NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(verb_data), .words(words)
  );

  smbx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
    .top_wr(wr_en[NBYTE-1]), .top_new(verb_data[BYTE_W-1]),
    .top_old(words[REG_W-1]), .kick_hit(kick_hit),
    .kick_nonzero(|verb_data), .irq_ack(irq_ack),
    .irq_event(irq_event), .irq_pulse(irq_pulse), .irq_pending(irq_pending)
  );

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < SMBX_NREG; r++)
      if (rd_en[r]) rd_word = words[r*REG_W +: REG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= verb_valid;
      rsp_data  <= rd_word;
    end
  end

  assign scratch0_out = words[0 +: REG_W];
  assign scratch1_out = words[REG_W +: REG_W];
endmodule

// File: rtl/smbx_checks.sv
module smbx_checks #(
  parameter logic [11:0] RD0_VERB  = 12'hFA6,
  parameter logic [11:0] INTR_VERB = 12'hF80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        verb_valid,
  input logic [11:0] verb_id,
  input logic [7:0]  verb_data,
  input logic        legacy_mode,
  input logic        irq_ack,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        irq_pulse,
  input logic        irq_pending,
  input logic [31:0] scratch0_out,
  input logic [31:0] scratch1_out,
  input logic        irq_event,
  input logic        verb_unknown
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(verb_valid));

  assert_read_old_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (verb_valid && verb_id == RD0_VERB) |=> (rsp_data == $past(scratch0_out)));

  assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    verb_unknown |=> (rsp_data == 32'h0 && $stable(scratch0_out) && $stable(scratch1_out)));

  assert_toggle_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(legacy_mode) && scratch0_out[31] != $past(scratch0_out[31])) |-> irq_pulse);

  assert_toggle_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(legacy_mode) && irq_pulse) |-> (scratch0_out[31] != $past(scratch0_out[31])));

  assert_kick_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(legacy_mode) && irq_pulse)
      |-> $past(verb_valid && verb_id == INTR_VERB && verb_data != 8'h0));

  assert_pending_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_event) |=> !irq_pending);

  assert_pending_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_ack) |=> irq_pending);

  assert_pulse_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_pending);
endmodule

bind scratch_mailbox smbx_checks u_chk (
  .clk(clk), .rst_n(rst_n), .verb_valid(verb_valid), .verb_id(verb_id),
  .verb_data(verb_data), .legacy_mode(legacy_mode), .irq_ack(irq_ack),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_pulse(irq_pulse),
  .irq_pending(irq_pending), .scratch0_out(scratch0_out),
  .scratch1_out(scratch1_out), .irq_event(irq_event), .verb_unknown(verb_unknown)
);

// File: tb/test_scratch_mailbox.sv
module test_scratch_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        verb_valid = 1'b0;
  logic [11:0] verb_id = '0;
  logic [7:0]  verb_data = '0;
  logic        legacy_mode = 1'b1;
  logic        irq_ack = 1'b0;
  logic        rsp_valid, irq_pulse, irq_pending;
  logic [31:0] rsp_data, scratch0_out, scratch1_out;

  int checks = 0;
  int errors = 0;

  // Model state
  logic [31:0] m_w0 = '0, m_w1 = '0, m_rsp = '0;
  logic        m_rv = 1'b0, m_pulse = 1'b0, m_pend = 1'b0, m_legacy_prev = 1'b1;

  always #2 clk = ~clk;

  scratch_mailbox i_scratch_mailbox (
    .clk(clk), .rst_n(rst_n), .verb_valid(verb_valid), .verb_id(verb_id),
    .verb_data(verb_data), .legacy_mode(legacy_mode), .irq_ack(irq_ack),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_pulse(irq_pulse),
    .irq_pending(irq_pending), .scratch0_out(scratch0_out), .scratch1_out(scratch1_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_w0 = '0; m_w1 = '0; m_rsp = '0; m_rv = 0; m_pulse = 0; m_pend = 0;
    end else begin
      logic ev;
      m_legacy_prev = legacy_mode;
      m_rv  = verb_valid;
      m_rsp = 32'h0;
      ev = 1'b0;
      if (verb_valid) begin
        if (verb_id == 12'hFA6) m_rsp = m_w0;
        if (verb_id == 12'hFAB) m_rsp = m_w1;
        if (legacy_mode && verb_id == 12'hFAA && verb_data[7] != m_w0[31]) ev = 1'b1;
        if (!legacy_mode && verb_id == 12'hF80 && verb_data != 0) ev = 1'b1;
        case (verb_id)
          12'hFA7: m_w0[7:0]   = verb_data;
          12'hFA8: m_w0[15:8]  = verb_data;
          12'hFA9: m_w0[23:16] = verb_data;
          12'hFAA: m_w0[31:24] = verb_data;
          12'hFAC: m_w1[7:0]   = verb_data;
          12'hFAD: m_w1[15:8]  = verb_data;
          12'hFAE: m_w1[23:16] = verb_data;
          12'hFAF: m_w1[31:24] = verb_data;
          default: ;
        endcase
      end
      m_pulse = ev;
      if (ev) m_pend = 1'b1;
      else if (irq_ack) m_pend = 1'b0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 rsp_valid", {31'h0, rsp_valid}, {31'h0, m_rv});
      check("R1 rsp_data", rsp_data, m_rsp);
      check("R2 scratch0", scratch0_out, m_w0);
      check("R3 scratch1", scratch1_out, m_w1);
      check(m_legacy_prev ? "R5 irq_pulse" : "R6 irq_pulse", {31'h0, irq_pulse}, {31'h0, m_pulse});
      check("R7 irq_pending", {31'h0, irq_pending}, {31'h0, m_pend});
    end
  end

  task automatic verb(input logic [11:0] id, input logic [7:0] d);
    verb_valid = 1'b1; verb_id = id; verb_data = d;
    @(negedge clk);
    verb_valid = 1'b0; verb_id = '0; verb_data = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check("R8 scratch0", scratch0_out, 32'h0);
    check("R8 scratch1", scratch1_out, 32'h0);
    check("R8 pend", {31'h0, irq_pending}, 32'h0);

    // Toggle mode: build a valid format, bit 31 stays 0
    verb(12'hFA7, 8'h34); verb(12'hFA8, 8'h12); verb(12'hFA9, 8'h00); verb(12'hFAA, 8'h40);
    verb(12'hFA6, 8'h00);
    check("R2 read", rsp_data, 32'h4000_1234);
    verb(12'hFAA, 8'hC0);   // flip -> pulse (R5)
    verb(12'hFAA, 8'hC0);   // same -> none
    check("R7 pending held", {31'h0, irq_pending}, 32'h1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    verb(12'hFAA, 8'h40);   // flip back -> pulse
    verb(12'hF80, 8'h01);   // ignored in toggle mode (R5)
    idle(2);

    // Word 1 lanes
    verb(12'hFAC, 8'hA1); verb(12'hFAD, 8'hB2); verb(12'hFAE, 8'hC3); verb(12'hFAF, 8'hD4);
    verb(12'hFAB, 8'h00);
    check("R3 read", rsp_data, 32'hD4C3_B2A1);

    // R4: read right after write
    verb(12'hFA7, 8'h5A);
    verb(12'hFA6, 8'h00);
    check("R4 back-to-back", rsp_data, 32'h4000_125A);

    // R9: unknown IDs
    verb(12'hFB0, 8'hFF);
    check("R9 rsp zero", rsp_data, 32'h0);
    verb(12'h123, 8'h77);
    verb(12'hFA5, 8'h11);
    check("R9 words", scratch0_out ^ scratch1_out, 32'h4000_125A ^ 32'hD4C3_B2A1);

    // Kick mode
    legacy_mode = 1'b0;
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    verb(12'hFAA, 8'hC0);   // bit flip: no pulse (R6)
    verb(12'hFAA, 8'h40);
    verb(12'hF80, 8'h00);   // zero payload: nothing
    check("R6 no pend", {31'h0, irq_pending}, 32'h0);
    verb(12'hF80, 8'h05);   // kick
    check("R6 pulse", {31'h0, irq_pulse}, 32'h1);
    // kick and acknowledge together: set wins (R7)
    irq_ack = 1'b1;
    verb(12'hF80, 8'h01);
    irq_ack = 1'b0;
    check("R7 set wins", {31'h0, irq_pending}, 32'h1);
    idle(1);
    check("R7 one-cycle pulse", {31'h0, irq_pulse}, 32'h0);

    // Disable audio: format zero, valid cleared
    verb(12'hFA7, 8'h00); verb(12'hFA8, 8'h00); verb(12'hFAA, 8'h00);
    verb(12'hFA6, 8'h00);
    check("R2 disabled", rsp_data, 32'h0);

    // Mid-run reset (R8)
    legacy_mode = 1'b1;
    verb(12'hFAF, 8'h99);
    rst_n = 1'b0;
    idle(2);
    check("R8 rst scratch1", scratch1_out, 32'h0);
    check("R8 rst pend", {31'h0, irq_pending}, 32'h0);
    rst_n = 1'b1;
    idle(3);
    finish_run();
  end
endmodule